// File: doc/BRIEF.md
# Looping Command Queue Sequencer

This block is a circular command queue that feeds a downstream consumer through a valid/ready port. Each stored word carries a payload and two control flags: a loop flag and a stop flag. Two asynchronous trigger inputs drive the sequencing. Their names are Advance and Repeat, and each is synchronized and reduced to a single rising-edge event. Advance arms the Repeat detector. Repeat starts command delivery.

A loop begins when the first command after a Repeat event has its loop flag set. The commands of that loop are not removed from the queue when they are delivered. A command with both flags set ends one pass of the loop: delivery stops and the read position returns to the start of the loop, so that the next Repeat event replays the loop. While the loop is parked, an Advance event discards the loop and moves delivery past it. Outside a loop, a stop-only command disarms the Repeat detector until the next Advance event. Status outputs report the stored entry count, the read index, the sequencer state and a sticky underflow flag.

Top module: `loopq_seq`

## Requirements
- R1: After reset the count is 0, the state is 0 (disarmed), xfer_valid is 0 and underflow is 0.
- R2: A Repeat edge that arrives in state 0 is discarded. The state stays 0 and no command is offered.
- R3: An Advance edge in state 0 moves the state to 1 (armed). A Repeat edge in state 1 moves it to 2 (running). In state 2, stored commands are offered in push order.
- R4: Outside a loop, each accepted transfer lowers the count by one and advances xfer_idx by one, modulo DEPTH.
- R5: Outside a loop, accepting a command with the stop flag (bit CMD_W) set and the loop flag (bit CMD_W+1) clear returns the state to 0.
- R6: If the first command accepted after a Repeat edge has the loop flag set, a loop starts. Commands accepted inside the loop leave the count unchanged.
- R7: Accepting a command with both flags set inside a loop sets the state to 1 and sets xfer_idx back to the loop's first entry. The next Repeat edge replays the same commands.
- R8: An Advance edge in state 1 while a loop is parked sets xfer_idx to the entry after the command that has both flags set. It lowers the count by the loop length and keeps the state at 1.
- R9: A push while the count equals DEPTH is ignored. The count stays at DEPTH, and the stored commands and their order are unaffected.
- R10: In state 2 with nothing to deliver, underflow is set and stays set, and xfer_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Write one command this cycle |
| push_data | input | CMD_W+2 | Command: bit CMD_W+1 is the loop flag, bit CMD_W is the stop flag, and the lower bits are the payload |
| adv_trig | input | 1 | Advance trigger, asynchronous level |
| rep_trig | input | 1 | Repeat trigger, asynchronous level |
| xfer_ready | input | 1 | Consumer accepts the offered command |
| xfer_valid | output | 1 | A command is offered |
| xfer_data | output | CMD_W+2 | Offered command word |
| xfer_idx | output | $clog2(DEPTH) | Index of the offered entry |
| count_o | output | $clog2(DEPTH)+1 | Stored entry count |
| state_o | output | 2 | 0 disarmed, 1 armed, 2 running |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with DEPTH=4 and CMD_W=8. With a depth of four, a handful of pushes fills the queue, and the read, write and loop pointers all wrap past the last slot inside one scenario. A three-command loop is placed across that wrap point. The bench then checks that replay returns to the right index and that breaking the loop removes exactly three entries.

// File: rtl/loopq_pkg.sv
package loopq_pkg;
  typedef enum logic [1:0] {
    ST_DISARMED = 2'd0,
    ST_ARMED    = 2'd1,
    ST_RUN      = 2'd2
  } qstate_e;
endpackage

// File: rtl/loopq_edge.sv
module loopq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/loopq_mem.sv
module loopq_mem #(
  parameter int DEPTH = 8,
  parameter int W     = 10,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic [PW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d;

  always_comb begin
    wptr_d = wptr_q;
    if (wr_en) wptr_d = wptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr_q <= '0;
    else        wptr_q <= wptr_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/loopq_ctrl.sv
module loopq_ctrl
  import loopq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_rise,
  input  logic          rep_rise,
  input  logic          push_valid,
  input  logic          xfer_ready,
  input  logic          flag_loop,
  input  logic          flag_stop,
  output logic          push_en,
  output logic          xfer_valid,
  output logic [PW-1:0] xptr_o,
  output logic [CW-1:0] count_o,
  output qstate_e       state_o,
  output logic          underflow_o
);
  qstate_e       st_q, st_d;
  logic [CW-1:0] count_q, count_d, held_q, held_d, avail;
  logic [PW-1:0] xptr_q, xptr_d, rptr_q, rptr_d, lend_q, lend_d;
  logic          looping_q, looping_d, closed_q, closed_d;
  logic          first_q, first_d, unf_q, unf_d;
  logic          fire, start_loop, in_loop, pop, drop;

  always_comb begin
    push_en    = push_valid && (count_q != CW'(DEPTH));
    avail      = (looping_q && !closed_q) ? (count_q - held_q) : count_q;
    xfer_valid = (st_q == ST_RUN) && (avail != '0);
    fire       = xfer_valid && xfer_ready;
    start_loop = first_q && flag_loop;
    in_loop    = looping_q || start_loop;

    st_d      = st_q;
    xptr_d    = xptr_q;
    rptr_d    = rptr_q;
    lend_d    = lend_q;
    held_d    = held_q;
    looping_d = looping_q;
    closed_d  = closed_q;
    first_d   = first_q;
    unf_d     = unf_q;
    pop       = 1'b0;
    drop      = 1'b0;

    unique case (st_q)
      ST_DISARMED: begin
        if (adv_rise) st_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (rep_rise) begin
          st_d    = ST_RUN;
          first_d = !looping_q;
        end else if (adv_rise && looping_q && closed_q) begin
          xptr_d    = lend_q;
          drop      = 1'b1;
          looping_d = 1'b0;
          closed_d  = 1'b0;
          held_d    = '0;
        end
      end
      ST_RUN: begin
        if (avail == '0) unf_d = 1'b1;
        if (fire) begin
          first_d = 1'b0;
          if (in_loop) begin
            if (start_loop) begin
              looping_d = 1'b1;
              rptr_d    = xptr_q;
            end
            if (!closed_q) held_d = held_q + CW'(1);
            if (flag_loop && flag_stop) begin
              closed_d = 1'b1;
              lend_d   = xptr_q + PW'(1);
              xptr_d   = start_loop ? xptr_q : rptr_q;
              st_d     = ST_ARMED;
            end else begin
              xptr_d = xptr_q + PW'(1);
            end
          end else begin
            pop    = 1'b1;
            xptr_d = xptr_q + PW'(1);
            if (flag_stop && !flag_loop) st_d = ST_DISARMED;
          end
        end
      end
      default: st_d = ST_DISARMED;
    endcase

    count_d = count_q + CW'(push_en) - CW'(pop) - (drop ? held_q : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_DISARMED;
      count_q   <= '0;
      held_q    <= '0;
      xptr_q    <= '0;
      rptr_q    <= '0;
      lend_q    <= '0;
      looping_q <= 1'b0;
      closed_q  <= 1'b0;
      first_q   <= 1'b0;
      unf_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      count_q   <= count_d;
      held_q    <= held_d;
      xptr_q    <= xptr_d;
      rptr_q    <= rptr_d;
      lend_q    <= lend_d;
      looping_q <= looping_d;
      closed_q  <= closed_d;
      first_q   <= first_d;
      unf_q     <= unf_d;
    end
  end

  assign xptr_o      = xptr_q;
  assign count_o     = count_q;
  assign state_o     = st_q;
  assign underflow_o = unf_q;
endmodule

// File: rtl/loopq_seq.sv
module loopq_seq
  import loopq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CMD_W = 16,
  localparam int W    = CMD_W + 2,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [W-1:0]  push_data,
  input  logic          adv_trig,
  input  logic          rep_trig,
  input  logic          xfer_ready,
  output logic          xfer_valid,
  output logic [W-1:0]  xfer_data,
  output logic [PW-1:0] xfer_idx,
  output logic [CW-1:0] count_o,
  output logic [1:0]    state_o,
  output logic          underflow_o
);
  logic [1:0]    trig_raw, trig_rise;
  logic          push_en;
  logic [W-1:0]  rd_word;
  logic [PW-1:0] xptr;
  qstate_e       st;

  assign trig_raw = {rep_trig, adv_trig};

  for (genvar g = 0; g < 2; g++) begin : g_trig
    loopq_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(trig_raw[g]),
      .rise_o (trig_rise[g])
    );
  end

  loopq_mem #(.DEPTH(DEPTH), .W(W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (push_en),
    .wr_data(push_data),
    .rd_addr(xptr),
    .rd_data(rd_word)
  );

  loopq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_rise   (trig_rise[0]),
    .rep_rise   (trig_rise[1]),
    .push_valid (push_valid),
    .xfer_ready (xfer_ready),
    .flag_loop  (rd_word[W-1]),
    .flag_stop  (rd_word[W-2]),
    .push_en    (push_en),
    .xfer_valid (xfer_valid),
    .xptr_o     (xptr),
    .count_o    (count_o),
    .state_o    (st),
    .underflow_o(underflow_o)
  );

  assign xfer_data = rd_word;
  assign xfer_idx  = xptr;
  assign state_o   = st;
endmodule

// File: rtl/loopq_chk.sv
module loopq_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          xfer_valid,
  input logic [CW-1:0] count_o,
  input logic [1:0]    state_o,
  input logic          underflow_o
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH)); // R9

  AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && count_o == CW'(DEPTH) && push_valid) |=> count_o == CW'(DEPTH)); // R9

  AST_VALID_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> state_o == 2'd2); // R3

  AST_DISARMED_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'd0 |=> state_o != 2'd2); // R2

  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> underflow_o); // R10

  AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    count_o == '0 |-> !xfer_valid); // R10
endmodule

bind loopq_seq loopq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .xfer_valid (xfer_valid),
  .count_o    (count_o),
  .state_o    (state_o),
  .underflow_o(underflow_o)
);

// File: tb/sim_loopq_seq.sv
`timescale 1ns/1ps
module sim_loopq_seq;
  localparam int DEPTH = 4;
  localparam int CMD_W = 8;
  localparam int W     = CMD_W + 2;

  logic         clk, rst_n, push_valid, adv_trig, rep_trig, xfer_ready;
  logic [W-1:0] push_data, xfer_data;
  logic         xfer_valid, underflow_o;
  logic [1:0]   xfer_idx, state_o;
  logic [2:0]   count_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  loopq_seq #(.DEPTH(DEPTH), .CMD_W(CMD_W)) u0 (
    .clk, .rst_n, .push_valid, .push_data, .adv_trig, .rep_trig, .xfer_ready,
    .xfer_valid, .xfer_data, .xfer_idx, .count_o, .state_o, .underflow_o
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] mk(input bit lp, input bit st, input int pl);
    return {lp, st, 8'(pl)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] w);
    @(negedge clk);
    push_valid = 1'b1;
    push_data  = w;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic pulse_adv();
    @(negedge clk);
    adv_trig = 1'b1;
    repeat (3) @(negedge clk);
    adv_trig = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_rep();
    @(negedge clk);
    rep_trig = 1'b1;
    repeat (3) @(negedge clk);
    rep_trig = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic take(input logic [W-1:0] exp, input string req);
    int t = 0;
    @(negedge clk);
    while (!xfer_valid && t < 30) begin
      @(negedge clk);
      t++;
    end
    chk(req, int'(xfer_valid), 1);
    chk(req, int'(xfer_data), int'(exp));
    xfer_ready = 1'b1;
    @(negedge clk);
    xfer_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", int'(count_o), 0);
    chk("R1 state", int'(state_o), 0);
    chk("R1 valid", int'(xfer_valid), 0);
    chk("R1 underflow", int'(underflow_o), 0);
  endtask

  task automatic t_disarmed_repeat();
    push(mk(0, 0, 8'h11));
    push(mk(0, 1, 8'h22));
    pulse_rep();
    chk("R2 state", int'(state_o), 0);
    chk("R2 valid", int'(xfer_valid), 0);
    chk("R2 count", int'(count_o), 2);
  endtask

  task automatic t_plain_run();
    pulse_adv();
    chk("R3 armed", int'(state_o), 1);
    pulse_rep();
    chk("R3 run", int'(state_o), 2);
    chk("R3 idx", int'(xfer_idx), 0);
    take(mk(0, 0, 8'h11), "R3 first data");
    chk("R4 count", int'(count_o), 1);
    chk("R4 idx", int'(xfer_idx), 1);
    take(mk(0, 1, 8'h22), "R3 second data");
    chk("R5 disarmed", int'(state_o), 0);
    chk("R4 count empty", int'(count_o), 0);
    chk("R4 idx", int'(xfer_idx), 2);
  endtask

  task automatic t_loop();
    push(mk(1, 0, 8'h31));
    push(mk(0, 0, 8'h32));
    push(mk(1, 1, 8'h33));
    push(mk(0, 1, 8'h34));
    pulse_adv();
    pulse_rep();
    take(mk(1, 0, 8'h31), "R6 loop A");
    chk("R6 count kept", int'(count_o), 4);
    take(mk(0, 0, 8'h32), "R6 loop B");
    take(mk(1, 1, 8'h33), "R7 loop end");
    chk("R7 parked", int'(state_o), 1);
    chk("R7 idx back", int'(xfer_idx), 2);
    chk("R6 count kept", int'(count_o), 4);
    pulse_rep();
    take(mk(1, 0, 8'h31), "R7 replay A");
    take(mk(0, 0, 8'h32), "R7 replay B");
    take(mk(1, 1, 8'h33), "R7 replay end");
    chk("R7 parked again", int'(state_o), 1);
    chk("R7 idx back", int'(xfer_idx), 2);
    pulse_adv();
    chk("R8 idx past", int'(xfer_idx), 1);
    chk("R8 count", int'(count_o), 1);
    chk("R8 state", int'(state_o), 1);
    pulse_rep();
    take(mk(0, 1, 8'h34), "R8 after loop");
    chk("R5 disarmed", int'(state_o), 0);
    chk("R4 count", int'(count_o), 0);
  endtask

  task automatic t_full();
    push(mk(0, 0, 8'h41));
    push(mk(0, 0, 8'h42));
    push(mk(0, 0, 8'h43));
    push(mk(0, 1, 8'h44));
    push(mk(0, 1, 8'h45));
    chk("R9 count", int'(count_o), 4);
    pulse_adv();
    pulse_rep();
    take(mk(0, 0, 8'h41), "R9 order");
    take(mk(0, 0, 8'h42), "R9 order");
    take(mk(0, 0, 8'h43), "R9 order");
    take(mk(0, 1, 8'h44), "R9 order");
    chk("R9 drained", int'(count_o), 0);
    chk("R5 disarmed", int'(state_o), 0);
  endtask

  task automatic t_underflow();
    pulse_adv();
    pulse_rep();
    chk("R10 run", int'(state_o), 2);
    chk("R10 underflow", int'(underflow_o), 1);
    chk("R10 valid", int'(xfer_valid), 0);
    push(mk(0, 1, 8'h46));
    take(mk(0, 1, 8'h46), "R9 pointer intact");
    chk("R10 sticky", int'(underflow_o), 1);
    chk("R5 disarmed", int'(state_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; push_valid = 1'b0; push_data = '0;
    adv_trig = 1'b0; rep_trig = 1'b0; xfer_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disarmed_repeat();
    t_plain_run();
    t_loop();
    t_full();
    t_underflow();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule